// File: doc/BRIEF.md
# I2C Clock Period Generator

This block produces the serial clock of an I2C controller from a counter running on the system clock. Two pairs of period counts, one for standard mode and one for fast mode, set how long SCL is held low and how long it stays released. A mode input picks the pair. The block pulls SCL low through an open-drain enable. After releasing the line, it waits until the sampled SCL level reads high before it times the high phase. A target that holds the line low therefore stretches the low phase.

Turning the block on or off goes through a status handshake. The status output follows the request only at a safe point. Enabling takes effect at once from idle. Disabling waits until the current high phase has run out, so a half period is never cut short. Start and stop sequencing and data shifting are left to the surrounding controller. The count inputs and the mode input are meant to change only while the status reads disabled.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, `scl_oe`, `scl_rise` and `en_status` are all 0.
- R2: When `en_req` is sampled 1 while the block is idle, `en_status` and `scl_oe` both read 1 in the following cycle.
- R3: Each low phase keeps `scl_oe` at 1 for exactly L+1 consecutive cycles. L is the selected low count, and the count starts in the first cycle the line is pulled low.
- R4: Each high phase lasts exactly H+8 cycles with `scl_oe` at 0, where H is the selected high count. The phase starts in the cycle `scl_rise` is 1. After it, the next low phase begins or, if disabled, the block goes idle.
- R5: `fast_sel`=1 selects `fs_hcnt`/`fs_lcnt` and `fast_sel`=0 selects `ss_hcnt`/`ss_lcnt`; the unselected pair has no effect on the periods.
- R6: A selected count of 0 behaves as a count of 1 (low phase 2 cycles, high phase 9 cycles).
- R7: After SCL is released, the block waits while `scl_in` reads 0. With the line held low for S sampled cycles, `scl_rise` appears S+1 cycles after the release, and no high timing starts before that.
- R8: `scl_rise` is a single-cycle pulse marking the first cycle of each high phase.
- R9: When `en_req` drops, `en_status` stays 1 until the running high phase has completed in full. `en_status` then falls to 0 together with the block returning to idle, with `scl_oe` 0.
- R10: While `en_status` is 0, `scl_oe` and `scl_rise` stay 0 whatever `scl_in` does. The next enable starts a full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Requested enable |
| fast_sel | input | 1 | 1 selects the fast-mode count pair |
| ss_hcnt | input | CNT_W | Standard-mode high count |
| ss_lcnt | input | CNT_W | Standard-mode low count |
| fs_hcnt | input | CNT_W | Fast-mode high count |
| fs_lcnt | input | CNT_W | Fast-mode low count |
| scl_in | input | 1 | Sampled (already synchronised) SCL level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_rise | output | 1 | One-cycle pulse when a released SCL is seen high |
| en_status | output | 1 | Acknowledged enable state |

## Verification
Enable status and the first pull-down are due one cycle after `en_req` is sampled. `scl_rise` is due one cycle after the first high sample of `scl_in`. The low and high phase lengths are measured as runs of cycles between these port events, not at fixed offsets. The bench drives inputs and reads outputs on the falling edge. It counts each phase run there and compares it with L+1, H+8 and S+1 from its own clamped copies of the selected counts when the run ends. The disable check waits for the status to fall and then confirms that the high run just ended was complete.

// File: rtl/scl_gen_pkg.sv
// Shared types and constants of the SCL period generator.
// Assumes nothing beyond a single clock domain.
package scl_gen_pkg;

    // Phases of one SCL period plus idle
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LOW     = 2'd1,
        PH_RELEASE = 2'd2,
        PH_HIGH    = 2'd3
    } scl_phase_e;

    // Fixed cycles added to the programmed high count
    localparam int HIGH_OVERHEAD = 8;

endpackage

// File: rtl/scl_count_sel.sv
// Selects the count pair for the active mode and turns it into phase limits.
// A zero count is clamped to 1. Low limit L gives L+1 cycles of low phase.
// High limit H+OVERHEAD-1 gives H+OVERHEAD cycles of high phase.
// Assumes the counts are stable while the generator runs.
module scl_count_sel
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             fast_sel,
    input  logic [CNT_W-1:0] ss_hcnt,
    input  logic [CNT_W-1:0] ss_lcnt,
    input  logic [CNT_W-1:0] fs_hcnt,
    input  logic [CNT_W-1:0] fs_lcnt,
    output logic [CNT_W:0]   low_lim,
    output logic [CNT_W:0]   high_lim
);
    localparam int HI_W   = CNT_W + 1;
    localparam int NMODES = 2;

    logic [CNT_W-1:0] raw_h [NMODES];
    logic [CNT_W-1:0] raw_l [NMODES];
    logic [CNT_W-1:0] clp_h [NMODES];
    logic [CNT_W-1:0] clp_l [NMODES];

    assign raw_h[0] = ss_hcnt;
    assign raw_l[0] = ss_lcnt;
    assign raw_h[1] = fs_hcnt;
    assign raw_l[1] = fs_lcnt;

    // Clamp every mode's counts to a minimum of one
    for (genvar g = 0; g < NMODES; g++) begin : g_clamp
        assign clp_h[g] = (raw_h[g] == '0) ? CNT_W'(1) : raw_h[g];
        assign clp_l[g] = (raw_l[g] == '0) ? CNT_W'(1) : raw_l[g];
    end

    // Pick the active pair and form the terminal values
    always_comb begin
        low_lim  = {1'b0, clp_l[fast_sel]};
        high_lim = {1'b0, clp_h[fast_sel]} + HI_W'(HIGH_OVERHEAD - 1);
    end

endmodule

// File: rtl/scl_phase_timer.sv
// Phase counter. It counts up from zero while run is high and returns to zero
// in the cycle after reaching the limit or whenever run is low. With limit N
// a phase lasts N+1 cycles. Assumes limit is steady during a phase.
module scl_phase_timer #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] count;

    assign done = run && (count == limit);

    // Advance inside a phase, fall back to zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (run && !done)
            count <= count + W'(1);
        else
            count <= '0;
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (count <= limit));

    // R10
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!run) && $past(rst_n)) |-> (count == '0));

endmodule

// File: rtl/scl_phase_fsm.sv
// Period sequencer: idle -> low -> release (wait for SCL high) -> high -> low.
// It owns the enable handshake. Status rises when leaving idle and falls only
// as a high phase completes with the request removed.
// Assumes scl_in is already synchronised to clk.
module scl_phase_fsm
    import scl_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_req,
    input  logic       scl_in,
    input  logic       done,
    output scl_phase_e phase,
    output logic       scl_rise,
    output logic       en_status
);
    scl_phase_e phase_nx;

    // Next-phase decision
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE:    if (en_req) phase_nx = PH_LOW;
            PH_LOW:     if (done)   phase_nx = PH_RELEASE;
            PH_RELEASE: if (scl_in) phase_nx = PH_HIGH;
            PH_HIGH:    if (done)   phase_nx = en_req ? PH_LOW : PH_IDLE;
            default:                phase_nx = PH_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // Rise pulse in the first high-phase cycle
    always_ff @(posedge clk) begin
        if (!rst_n) scl_rise <= 1'b0;
        else        scl_rise <= (phase == PH_RELEASE) && scl_in;
    end

    // Enable status follows the request only at safe points
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_status <= 1'b0;
        else if (phase == PH_IDLE && en_req)
            en_status <= 1'b1;
        else if (phase == PH_HIGH && done && !en_req)
            en_status <= 1'b0;
    end

    // R2
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_status) |-> ($past(en_req) && (phase == PH_LOW)));

    // R9
    en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_status) |-> (!$past(en_req) && $past(phase == PH_HIGH) && phase == PH_IDLE));

    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_status |-> (phase != PH_LOW));

    // R8
    rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |=> !scl_rise);

    // R7
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RELEASE && !scl_in) |=> (phase == PH_RELEASE && !scl_rise));

endmodule

// File: rtl/scl_timing_gen.sv
// Top of the SCL period generator. It joins count selection, the shared phase
// timer and the period sequencer. scl_oe=1 pulls the line low.
// Assumes the count and mode inputs change only while en_status is 0.
module scl_timing_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic             fast_sel,
    input  logic [CNT_W-1:0] ss_hcnt,
    input  logic [CNT_W-1:0] ss_lcnt,
    input  logic [CNT_W-1:0] fs_hcnt,
    input  logic [CNT_W-1:0] fs_lcnt,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             scl_rise,
    output logic             en_status
);
    localparam int TW = CNT_W + 1;

    logic [TW-1:0] low_lim;
    logic [TW-1:0] high_lim;
    logic [TW-1:0] cur_lim;
    logic          tmr_run;
    logic          tmr_done;
    scl_phase_e    phase;

    scl_count_sel #(.CNT_W(CNT_W)) u_sel (
        .fast_sel (fast_sel),
        .ss_hcnt  (ss_hcnt),
        .ss_lcnt  (ss_lcnt),
        .fs_hcnt  (fs_hcnt),
        .fs_lcnt  (fs_lcnt),
        .low_lim  (low_lim),
        .high_lim (high_lim)
    );

    // Timer runs only in the timed phases, with the matching limit
    always_comb begin
        tmr_run = (phase == PH_LOW) || (phase == PH_HIGH);
        cur_lim = (phase == PH_HIGH) ? high_lim : low_lim;
    end

    scl_phase_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .limit (cur_lim),
        .done  (tmr_done)
    );

    scl_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_req    (en_req),
        .scl_in    (scl_in),
        .done      (tmr_done),
        .phase     (phase),
        .scl_rise  (scl_rise),
        .en_status (en_status)
    );

    // Open-drain enable: low only during the low phase
    assign scl_oe = (phase == PH_LOW);

    // R10
    oe_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_status |-> (!scl_oe && !scl_rise));

    // R4
    rise_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> (!scl_oe && $past(!scl_oe) && $past(scl_in)));

endmodule

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en_req;
    logic             fast_sel;
    logic [CNT_W-1:0] ss_hcnt, ss_lcnt, fs_hcnt, fs_lcnt;
    logic             scl_in;
    logic             scl_oe, scl_rise, en_status;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done_flag = 0;

    // monitor state
    bit mon_on = 0;
    bit prev_oe = 0, prev_en = 0, prev_rise = 0;
    bit in_high = 0, waiting = 0;
    int low_run = 0, hi_run = 0, wait_run = 0;
    int stretch_cfg = 0, stretch_left = 0;
    int periods = 0;

    always #2.5 clk = ~clk;

    scl_timing_gen #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .fast_sel(fast_sel),
        .ss_hcnt(ss_hcnt), .ss_lcnt(ss_lcnt), .fs_hcnt(fs_hcnt), .fs_lcnt(fs_lcnt),
        .scl_in(scl_in), .scl_oe(scl_oe), .scl_rise(scl_rise), .en_status(en_status)
    );

    function automatic int clamp1(input logic [CNT_W-1:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    function automatic int exp_low();
        return clamp1(fast_sel ? fs_lcnt : ss_lcnt) + 1;
    endfunction

    function automatic int exp_high();
        return clamp1(fast_sel ? fs_hcnt : ss_hcnt) + 8;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            check(0, "watchdog", cycles, 150000);
            finish_run();
        end
    end

    // Port monitor and SCL line model
    always @(negedge clk) begin
        if (mon_on) begin
            if (in_high && (scl_oe || !en_status)) begin
                check(hi_run == exp_high(), "R4 high phase length", hi_run, exp_high());
                in_high = 0;
                if (!en_status) check(1, "R9 high phase complete before disable", 1, 1);
            end else if (prev_en && !en_status) begin
                check(0, "R9 status fell outside high end", 0, 1);
            end
            if (scl_rise && prev_rise) check(0, "R8 rise pulse width", 2, 1);
            if (!en_status) begin
                check(!scl_oe && !scl_rise, "R10 idle outputs", {scl_oe, scl_rise}, 0);
                scl_in = 1'($urandom % 2);
                waiting = 0;
                low_run = 0;
            end else if (scl_oe) begin
                low_run++;
                stretch_left = stretch_cfg;
                waiting = 0;
                scl_in = 1'b0;
            end else begin
                if (prev_oe) begin
                    check(low_run == exp_low(), "R3 R5 R6 low phase length", low_run, exp_low());
                    low_run = 0;
                    waiting = 1;
                    wait_run = 0;
                end
                if (scl_rise) begin
                    check(waiting && wait_run == stretch_cfg + 1, "R7 release wait", wait_run, stretch_cfg + 1);
                    waiting = 0;
                    in_high = 1;
                    hi_run = 1;
                    periods++;
                end else if (in_high) begin
                    hi_run++;
                end else if (waiting) begin
                    wait_run++;
                end
                if (waiting && stretch_left > 0) begin
                    scl_in = 1'b0;
                    stretch_left--;
                end else begin
                    scl_in = 1'b1;
                end
            end
            prev_oe = scl_oe;
            prev_en = en_status;
            prev_rise = scl_rise;
        end
    end

    task automatic run_case(input bit fs, input int sh, input int sl, input int fh,
                            input int fl, input int st, input int nper);
        int target;
        int hold;
        @(negedge clk);
        fast_sel = fs;
        ss_hcnt = CNT_W'(sh); ss_lcnt = CNT_W'(sl);
        fs_hcnt = CNT_W'(fh); fs_lcnt = CNT_W'(fl);
        stretch_cfg = st;
        en_req = 1'b1;
        target = periods + nper;
        @(negedge clk);
        check(en_status && scl_oe, "R2 enable acknowledge", {en_status, scl_oe}, 3);
        while (periods < target) @(negedge clk);
        hold = $urandom % 6;
        repeat (hold) @(negedge clk);
        while (!scl_oe) @(negedge clk);
        en_req = 1'b0;
        @(negedge clk);
        check(en_status, "R9 status held after request drop", en_status, 1);
        while (en_status) @(negedge clk);
        check(!scl_oe, "R9 released when disabled", scl_oe, 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; en_req = 0; fast_sel = 0; scl_in = 1;
        ss_hcnt = 0; ss_lcnt = 0; fs_hcnt = 0; fs_lcnt = 0;
        repeat (3) @(negedge clk);
        check(!scl_oe && !scl_rise && !en_status, "R1 reset state", {scl_oe, scl_rise, en_status}, 0);
        rst_n = 1;
        @(negedge clk);
        check(!scl_oe && !scl_rise && !en_status, "R1 after reset", {scl_oe, scl_rise, en_status}, 0);
        mon_on = 1;
        repeat (6) @(negedge clk);
        // directed: standard mode, fast mode with distinct other pair
        run_case(0, 3, 4, 20, 30, 0, 3);
        run_case(1, 25, 35, 2, 6, 0, 3);
        // R6 zero counts clamp to one
        run_case(0, 0, 0, 9, 9, 0, 3);
        run_case(1, 9, 9, 0, 0, 0, 2);
        // R7 stretched release
        run_case(0, 2, 2, 0, 0, 3, 3);
        run_case(1, 0, 0, 5, 1, 7, 2);
        // larger counts
        run_case(0, 60, 47, 1, 1, 1, 2);
        // constrained random
        for (int i = 0; i < 12; i++) begin
            run_case(1'($urandom % 2), $urandom % 24, $urandom % 24,
                     $urandom % 24, $urandom % 24, $urandom % 5, 1 + $urandom % 3);
        end
        finish_run();
    end
endmodule